// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block is the internal DMA engine of a storage host controller. Software builds a list of 16-byte descriptors in memory, each pointing at a data buffer, then points the engine at the head of the list and turns it on. The engine reads each descriptor and checks that the descriptor is handed over to it. It then moves the buffer between memory and the controller's data FIFO: memory to FIFO when transmitting, FIFO to memory when receiving. Each finished descriptor is returned to software by writing its config word back with the ownership bit cleared.

The walk follows the list sequentially, through explicit next pointers, or back to the list head, as each descriptor selects. It ends after a descriptor marked last. Outcomes are collected in a sticky status register: transfer completion, an invalid or unowned descriptor, a memory bus error, a card error and a host abort. Software clears status bits by writing ones to them. A soft reset returns the engine to idle. After an invalid descriptor, the engine can be told to fetch the same descriptor again.

Top module: `dmac_engine`

## Requirements
- R1: Register writes use reg_sel 0 for control, 1 for list base and 2 for status. A control write that sets bit 7 while the engine is off starts a walk at the list base address. A descriptor is four 32-bit words at consecutive addresses: config, buffer size in bytes, buffer address, next pointer. A memory request holds its address and direction until mem_ack.
- R2: After a descriptor that is not last, the next one is taken from the list base if config bit 5 (end of ring) is set. Otherwise it is taken from the next-pointer word if config bit 4 (chained) is set, and otherwise from the current descriptor address plus 16. The next-pointer word is ignored unless only bit 4 selects it.
- R3: With xfer_rx low, the engine reads ceil(size/4) words from the buffer in ascending address order. It pushes them to the FIFO in that order, and only in cycles where fifo_full is low.
- R4: With xfer_rx high, the engine pops ceil(size/4) words, only in cycles where fifo_empty is low. It writes them to the buffer in ascending address order.
- R5: A fetched descriptor whose config bit 31 (owned by engine) is clear, or whose size is 0 or above MAX_BUF_BYTES, moves no data. The engine stops, and status bits 4 and 9 are set.
- R6: A control write with bits 31 and 7 set, while the engine is stopped on an invalid descriptor, fetches that same descriptor again.
- R7: After a buffer is moved, the engine writes the config word back to the descriptor address with bit 31 cleared and the other bits kept. Bit 30 is also set if card_err was seen during that buffer.
- R8: After the write-back of a descriptor with config bit 2 (last), the engine goes idle and sets status bit 8. Unless config bit 1 is set, it also sets status bit 0 (xfer_rx low) or bit 1 (xfer_rx high).
- R9: A mem_ack with mem_err sets status bits 2 and 9. No further memory request is made until soft reset, even if the engine is turned off and on again.
- R10: A control write with bit 0 set clears status, the enable bit and the fixed-burst bit, and puts the engine in idle. The bit itself is not stored. Reset leaves status 0 and no request active.
- R11: A status write clears exactly the status bits written as 1.
- R12: A control write clearing bit 7 while a walk is in progress stops the walk, and no further memory request is made. Status bits 10 and 9 are set.
- R13: A card_err pulse sets status bits 5 and 9.
- R14: mem_fixed_burst follows control bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 list base, 2 status |
| reg_wdata | input | 32 | Register write data |
| dma_status | output | 32 | Sticky status bits |
| xfer_rx | input | 1 | Direction: 1 FIFO to memory, 0 memory to FIFO |
| card_err | input | 1 | Card error pulse from the protocol side |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted and completed |
| mem_err | input | 1 | Error response, valid with mem_ack |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_fixed_burst | output | 1 | Fixed burst mode selected |
| fifo_push | output | 1 | Push a word into the FIFO |
| fifo_wdata | output | 32 | Word pushed |
| fifo_full | input | 1 | FIFO cannot accept a word |
| fifo_pop | output | 1 | Take the head word from the FIFO |
| fifo_rdata | input | 32 | Head word of the FIFO |
| fifo_empty | input | 1 | FIFO has no word |

## Verification
On every cycle, the assertions check several properties. A memory request holds until acknowledged. An error response silences the memory port. FIFO strobes never fire against full or empty. Invalid-descriptor, bus-error, completion and soft-reset events always leave their marks in the status register on the next cycle. Only the bench's scenarios can show that the words arrive in order and in the right count, and that the walk takes the sequential, chained and ring paths. They also cover write-back contents, the refetch after ownership is restored, abort and card-error outcomes, and the silence after a bus error across a re-enable. These scenarios run under random memory latency and FIFO back-pressure.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  // register selects
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_BASE = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  // control bits
  localparam int CTL_SRST    = 0;
  localparam int CTL_FIXB    = 1;
  localparam int CTL_ON      = 7;
  localparam int CTL_REFETCH = 31;
  // descriptor config bits
  localparam int CFG_DIC   = 1;
  localparam int CFG_LAST  = 2;
  localparam int CFG_CHAIN = 4;
  localparam int CFG_RING  = 5;
  localparam int CFG_CES   = 30;
  localparam int CFG_OWN   = 31;
  // status bits
  localparam int ST_TX  = 0;
  localparam int ST_RX  = 1;
  localparam int ST_FBE = 2;
  localparam int ST_INV = 4;
  localparam int ST_CES = 5;
  localparam int ST_NIS = 8;
  localparam int ST_AIS = 9;
  localparam int ST_ABT = 10;
  localparam int ST_W   = 11;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_CHECK, S_RD, S_PUSH, S_POP, S_WR, S_WB, S_SUSP, S_HALT
  } walk_st_t;

  // words needed to carry a byte count (rounded up)
  function automatic logic [31:0] buf_words(input logic [31:0] sz);
    return (sz >> 2) + {31'd0, |sz[1:0]};
  endfunction

  function automatic logic size_ok(input logic [31:0] sz, input logic [31:0] lim);
    return (sz != 32'd0) && (sz <= lim);
  endfunction

  // ring beats chain, chain beats sequential
  function automatic logic [31:0] next_desc(input logic [31:0] cfg, input logic [31:0] cur,
                                            input logic [31:0] base, input logic [31:0] nxt);
    if (cfg[CFG_RING])       return base;
    else if (cfg[CFG_CHAIN]) return nxt;
    else                     return cur + 32'd16;
  endfunction
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic        ev_done,
  input  logic        ev_dic,
  input  logic        ev_rx,
  input  logic        ev_fbe,
  input  logic        ev_inv,
  input  logic        ev_abt,
  input  logic        card_err,
  output logic [31:0] status_o,
  output logic [31:0] base_o,
  output logic        fixb_o,
  output logic        srst_p,
  output logic        start_p,
  output logic        stop_p,
  output logic        refetch_p
);
  logic             on_q, fixb_q;
  logic [31:0]      base_q;
  logic [ST_W-1:0]  stat_q, set_v, clr_v;
  logic             ctl_wr, base_wr, stat_wr;

  assign ctl_wr  = reg_wr && (reg_sel == SEL_CTRL);
  assign base_wr = reg_wr && (reg_sel == SEL_BASE);
  assign stat_wr = reg_wr && (reg_sel == SEL_STAT);

  assign srst_p    = ctl_wr && reg_wdata[CTL_SRST];
  assign start_p   = ctl_wr && !reg_wdata[CTL_SRST] && reg_wdata[CTL_ON] && !on_q;
  assign stop_p    = ctl_wr && !reg_wdata[CTL_ON] && on_q;
  assign refetch_p = ctl_wr && !reg_wdata[CTL_SRST] && reg_wdata[CTL_ON] && reg_wdata[CTL_REFETCH];

  always_comb begin
    set_v         = '0;
    set_v[ST_TX]  = ev_done && !ev_dic && !ev_rx;
    set_v[ST_RX]  = ev_done && !ev_dic && ev_rx;
    set_v[ST_FBE] = ev_fbe;
    set_v[ST_INV] = ev_inv;
    set_v[ST_CES] = card_err;
    set_v[ST_NIS] = ev_done;
    set_v[ST_AIS] = ev_fbe || ev_inv || card_err || ev_abt;
    set_v[ST_ABT] = ev_abt;
    clr_v         = stat_wr ? reg_wdata[ST_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q <= 1'b0; fixb_q <= 1'b0; base_q <= '0; stat_q <= '0;
    end else begin
      if (base_wr) base_q <= reg_wdata;
      if (srst_p) begin
        on_q <= 1'b0; fixb_q <= 1'b0; stat_q <= '0;
      end else begin
        if (ctl_wr) begin
          on_q   <= reg_wdata[CTL_ON];
          fixb_q <= reg_wdata[CTL_FIXB];
        end
        stat_q <= (stat_q & ~clr_v) | set_v;
      end
    end
  end

  assign status_o = {{(32-ST_W){1'b0}}, stat_q};
  assign base_o   = base_q;
  assign fixb_o   = fixb_q;

  a_r5_invalid_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inv |=> (status_o[ST_INV] && status_o[ST_AIS]));
  a_r9_bus_error_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fbe |=> (status_o[ST_FBE] && status_o[ST_AIS]));
  a_r8_done_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && !ev_dic) |=> ((status_o[ST_TX] || status_o[ST_RX]) && status_o[ST_NIS]));
  a_r10_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    srst_p |=> (status_o == 32'd0 && !fixb_o));
endmodule

// File: rtl/dmac_walker.sv
module dmac_walker
  import dmac_pkg::*;
#(
  parameter int MAX_BUF_BYTES = 8192
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        srst_p,
  input  logic        start_p,
  input  logic        stop_p,
  input  logic        refetch_p,
  input  logic [31:0] base,
  input  logic        xfer_rx,
  input  logic        card_err,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  output logic        fifo_push,
  output logic [31:0] fifo_wdata,
  input  logic        fifo_full,
  output logic        fifo_pop,
  input  logic [31:0] fifo_rdata,
  input  logic        fifo_empty,
  output logic        ev_done,
  output logic        ev_dic,
  output logic        ev_rx,
  output logic        ev_fbe,
  output logic        ev_inv,
  output logic        ev_abt
);
  localparam int          LEN_W  = $clog2(MAX_BUF_BYTES / 4) + 1;
  localparam logic [31:0] MAX_SZ = 32'(MAX_BUF_BYTES);

  walk_st_t        st;
  logic [31:0]     cur, cfg, bsz, badr, bnxt, ptr, dat;
  logic [LEN_W-1:0] wleft;
  logic [1:0]      wcnt;
  logic            rx_q, ces_seen;

  // named internal events
  logic        abt_now, kill, ack_ok, ack_bad, desc_bad, last_word, in_xfer;
  logic [31:0] nwords, wb_word;

  assign abt_now   = stop_p && (st != S_IDLE) && (st != S_HALT);
  assign kill      = srst_p || abt_now;
  assign ack_ok    = mem_req && mem_ack && !mem_err;
  assign ack_bad   = mem_req && mem_ack && mem_err;
  assign desc_bad  = !cfg[CFG_OWN] || !size_ok(bsz, MAX_SZ);
  assign nwords    = buf_words(bsz);
  assign last_word = (wleft == LEN_W'(1));
  assign in_xfer   = (st == S_RD) || (st == S_PUSH) || (st == S_POP) || (st == S_WR);
  assign wb_word   = {1'b0, cfg[CFG_CES] | ces_seen, cfg[29:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cur <= '0; cfg <= '0; bsz <= '0; badr <= '0; bnxt <= '0;
      ptr <= '0; dat <= '0; wleft <= '0; wcnt <= '0; rx_q <= 1'b0; ces_seen <= 1'b0;
    end else if (kill) begin
      st <= S_IDLE; wcnt <= '0; ces_seen <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_p) begin
          cur <= base; wcnt <= '0; st <= S_FETCH;
        end
        S_FETCH: if (ack_bad) st <= S_HALT;
          else if (ack_ok) begin
            case (wcnt)
              2'd0: cfg  <= mem_rdata;
              2'd1: bsz  <= mem_rdata;
              2'd2: badr <= mem_rdata;
              default: bnxt <= mem_rdata;
            endcase
            wcnt <= wcnt + 2'd1;
            if (wcnt == 2'd3) st <= S_CHECK;
          end
        S_CHECK: if (desc_bad) st <= S_SUSP;
          else begin
            wleft <= nwords[LEN_W-1:0]; ptr <= badr; rx_q <= xfer_rx; ces_seen <= 1'b0;
            st <= xfer_rx ? S_POP : S_RD;
          end
        S_RD: if (ack_bad) st <= S_HALT;
          else if (ack_ok) begin dat <= mem_rdata; st <= S_PUSH; end
        S_PUSH: if (!fifo_full) begin
          ptr <= ptr + 32'd4; wleft <= wleft - LEN_W'(1);
          st <= last_word ? S_WB : S_RD;
        end
        S_POP: if (!fifo_empty) begin dat <= fifo_rdata; st <= S_WR; end
        S_WR: if (ack_bad) st <= S_HALT;
          else if (ack_ok) begin
            ptr <= ptr + 32'd4; wleft <= wleft - LEN_W'(1);
            st <= last_word ? S_WB : S_POP;
          end
        S_WB: if (ack_bad) st <= S_HALT;
          else if (ack_ok) begin
            if (cfg[CFG_LAST]) st <= S_IDLE;
            else begin
              cur <= next_desc(cfg, cur, base, bnxt); wcnt <= '0; st <= S_FETCH;
            end
          end
        S_SUSP: if (refetch_p) begin wcnt <= '0; st <= S_FETCH; end
        default: st <= S_HALT;
      endcase
      if (card_err && in_xfer) ces_seen <= 1'b1;
    end
  end

  always_comb begin
    mem_req   = (st == S_FETCH) || (st == S_RD) || (st == S_WR) || (st == S_WB);
    mem_we    = (st == S_WR) || (st == S_WB);
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_FETCH:    mem_addr = cur + {28'd0, wcnt, 2'b00};
      S_RD, S_WR: mem_addr = ptr;
      S_WB:       mem_addr = cur;
      default:    mem_addr = '0;
    endcase
    if (st == S_WR) mem_wdata = dat;
    else if (st == S_WB) mem_wdata = wb_word;
  end

  assign fifo_push  = (st == S_PUSH) && !fifo_full;
  assign fifo_wdata = dat;
  assign fifo_pop   = (st == S_POP) && !fifo_empty;

  assign ev_done = (st == S_WB) && ack_ok && cfg[CFG_LAST] && !kill;
  assign ev_dic  = cfg[CFG_DIC];
  assign ev_rx   = rx_q;
  assign ev_fbe  = ack_bad && !kill;
  assign ev_inv  = (st == S_CHECK) && desc_bad && !kill;
  assign ev_abt  = abt_now && !srst_p;

  a_r1_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !kill) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  a_r9_quiet_after_error: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_bad && !kill) |=> !mem_req);
  a_r3_push_gated: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !fifo_full);
  a_r4_pop_gated: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
  import dmac_pkg::*;
#(
  parameter int MAX_BUF_BYTES = 8192
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] dma_status,
  input  logic        xfer_rx,
  input  logic        card_err,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic [31:0] mem_rdata,
  output logic        mem_fixed_burst,
  output logic        fifo_push,
  output logic [31:0] fifo_wdata,
  input  logic        fifo_full,
  output logic        fifo_pop,
  input  logic [31:0] fifo_rdata,
  input  logic        fifo_empty
);
  logic [31:0] base;
  logic srst_p, start_p, stop_p, refetch_p;
  logic ev_done, ev_dic, ev_rx, ev_fbe, ev_inv, ev_abt;

  dmac_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ev_done(ev_done), .ev_dic(ev_dic), .ev_rx(ev_rx), .ev_fbe(ev_fbe), .ev_inv(ev_inv),
    .ev_abt(ev_abt), .card_err(card_err), .status_o(dma_status), .base_o(base),
    .fixb_o(mem_fixed_burst), .srst_p(srst_p), .start_p(start_p), .stop_p(stop_p),
    .refetch_p(refetch_p)
  );

  dmac_walker #(.MAX_BUF_BYTES(MAX_BUF_BYTES)) u_walker (
    .clk(clk), .rst_n(rst_n), .srst_p(srst_p), .start_p(start_p), .stop_p(stop_p),
    .refetch_p(refetch_p), .base(base), .xfer_rx(xfer_rx), .card_err(card_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .fifo_full(fifo_full),
    .fifo_pop(fifo_pop), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
    .ev_done(ev_done), .ev_dic(ev_dic), .ev_rx(ev_rx), .ev_fbe(ev_fbe),
    .ev_inv(ev_inv), .ev_abt(ev_abt)
  );
endmodule

// File: tb/dmac_engine_tb_top.sv
module dmac_engine_tb_top;
  localparam logic [31:0] OWN = 32'h8000_0000, CES = 32'h4000_0000, RING = 32'h20,
                          CHN = 32'h10, FST = 32'h08, LST = 32'h04, DIC = 32'h02;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0; logic [1:0] reg_sel = '0; logic [31:0] reg_wdata = '0;
  logic [31:0] dma_status;
  logic xfer_rx = 1'b0, card_err = 1'b0;
  logic mem_req, mem_we, mem_ack, mem_err, mem_fixed_burst;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic fifo_push, fifo_full, fifo_pop, fifo_empty;
  logic [31:0] fifo_wdata, fifo_rdata;

  always #2 clk = ~clk;

  dmac_engine dut_i (.*);

  // memory model
  logic [31:0] mem [0:4095];
  always @(posedge clk) begin
    if (!rst_n) begin mem_ack <= 1'b0; mem_err <= 1'b0; mem_rdata <= '0; end
    else if (mem_req && !mem_ack && ($urandom % 4 != 0)) begin
      mem_ack <= 1'b1;
      mem_err <= (mem_addr[31:16] != 16'd0);
      if (mem_addr[31:16] == 16'd0) begin
        if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[13:2]];
      end
    end else begin mem_ack <= 1'b0; mem_err <= 1'b0; end
  end

  // FIFO models
  logic [31:0] tx_got [0:1023];
  logic [31:0] rx_src [0:1023];
  int tx_n, rx_idx, rx_len, req_cnt;
  logic clr = 1'b0, force_full = 1'b0, full_stall, rx_stall;
  assign fifo_full  = full_stall || force_full;
  assign fifo_empty = rx_stall || (rx_idx >= rx_len);
  assign fifo_rdata = rx_src[rx_idx[9:0]];
  always @(posedge clk) begin
    if (!rst_n) begin tx_n <= 0; rx_idx <= 0; req_cnt <= 0; full_stall <= 1'b0; rx_stall <= 1'b0; end
    else begin
      if (clr) begin tx_n <= 0; rx_idx <= 0; end
      else begin
        if (fifo_push) begin tx_got[tx_n[9:0]] <= fifo_wdata; tx_n <= tx_n + 1; end
        if (fifo_pop) rx_idx <= rx_idx + 1;
      end
      if (mem_req) req_cnt <= req_cnt + 1;
      full_stall <= ($urandom % 4 == 0);
      rx_stall   <= ($urandom % 4 == 0);
    end
  end

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_w [0:255];
  int exp_a [0:255];
  int exp_n;
  int d_addr [0:7];
  logic [31:0] d_cfg [0:7];
  int d_n;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s: actual=%h expected=%h", rq, act, exp); end
  endtask

  function automatic int wcount(input int sz);
    return sz / 4 + ((sz % 4 != 0) ? 1 : 0);
  endfunction

  function automatic logic [31:0] done_status(input bit rx, input bit dic);
    return 32'h100 | (dic ? 32'h0 : (rx ? 32'h2 : 32'h1));
  endfunction

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic put_desc(input int a, input logic [31:0] c, input int sz, input int bufa, input int nx);
    mem[a/4] = c; mem[a/4+1] = sz; mem[a/4+2] = bufa; mem[a/4+3] = nx;
    d_addr[d_n] = a; d_cfg[d_n] = c; d_n++;
  endtask

  task automatic fill_buf(input int bufa, input int sz, input bit rx);
    for (int k = 0; k < wcount(sz); k++) begin
      logic [31:0] v;
      v = $urandom;
      if (rx) begin mem[bufa/4+k] = 32'h0; rx_src[exp_n] = v; end
      else mem[bufa/4+k] = v;
      exp_w[exp_n] = v; exp_a[exp_n] = bufa/4 + k; exp_n++;
    end
  endtask

  task automatic prep();
    exp_n = 0; d_n = 0; rx_len = 0;
  endtask

  task automatic go(input bit rx, input bit fixb);
    xfer_rx = rx;
    rx_len = rx ? exp_n : 0;
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
    wr(2'd1, 32'h100);
    wr(2'd0, 32'h0);
    wr(2'd2, 32'h7FF);
    wr(2'd0, 32'h80 | (fixb ? 32'h2 : 32'h0));
  endtask

  task automatic wait_stat(input logic [31:0] mask);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if ((dma_status & mask) != 0) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_data(input bit rx, input int upto, input string rq);
    int bad; bad = 0;
    for (int k = 0; k < upto; k++) begin
      if (rx) begin if (mem[exp_a[k]] !== exp_w[k]) bad++; end
      else if (tx_got[k] !== exp_w[k]) bad++;
    end
    chk(bad == 0, rq, bad, 0);
    if (!rx) chk(tx_n == upto, rq, tx_n, upto);
    else chk(rx_idx == upto, rq, rx_idx, upto);
  endtask

  task automatic check_wb(input int upto, input string rq);
    for (int i = 0; i < upto; i++)
      chk(mem[d_addr[i]/4] === (d_cfg[i] & ~OWN), rq, mem[d_addr[i]/4], d_cfg[i] & ~OWN);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    int base_req;
    void'($urandom(32'h1D5E_ED01));
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R10)
    chk(dma_status == 32'h0, "R10 reset status", dma_status, 0);
    chk(!mem_req && !fifo_push && !fifo_pop, "R10 reset idle", {mem_req, fifo_push, fifo_pop}, 0);
    chk(!mem_fixed_burst, "R14 reset fixed", mem_fixed_burst, 0);

    // single transmit descriptor, fixed burst (R3 R7 R8 R14)
    prep();
    put_desc(32'h100, OWN | FST | LST, 20, 32'h1000, 32'h0);
    fill_buf(32'h1000, 20, 1'b0);
    go(1'b0, 1'b1);
    chk(mem_fixed_burst, "R14 fixed burst", mem_fixed_burst, 1);
    wait_stat(32'h100);
    chk(dma_status == 32'h101, "R8 tx done", dma_status, 32'h101);
    check_data(1'b0, exp_n, "R3 tx words");
    check_wb(d_n, "R7 writeback");
    // W1C (R11)
    wr(2'd2, 32'h1);
    @(negedge clk);
    chk(dma_status == 32'h100, "R11 w1c", dma_status, 32'h100);

    // random chains (R1 R2 R3 R4 R8)
    for (int it = 0; it < 8; it++) begin
      int n, a; bit rx, dic;
      n = 1 + $urandom % 4; rx = it[0]; dic = $urandom % 2; a = 32'h100;
      prep();
      for (int i = 0; i < n; i++) begin
        int sz, nx; bit ch; logic [31:0] c;
        sz = 1 + $urandom % 64; ch = $urandom % 2; nx = a + (ch ? 32 : 16);
        c = OWN | (i == 0 ? FST : 0) | (ch ? CHN : 0) | ((i == n - 1) ? (LST | (dic ? DIC : 0)) : 0);
        put_desc(a, c, sz, 32'h1000 + 32'h100 * i, ch ? nx : ($urandom & 32'h3FF0));
        fill_buf(32'h1000 + 32'h100 * i, sz, rx);
        a = nx;
      end
      go(rx, 1'b0);
      wait_stat(32'h100);
      chk(dma_status == done_status(rx, dic), rx ? "R4 R8 rx status" : "R3 R8 tx status",
          dma_status, done_status(rx, dic));
      check_data(rx, exp_n, rx ? "R4 R1 R2 rx data" : "R3 R1 R2 tx data");
      check_wb(d_n, "R7 R2 writeback");
    end

    // ownership clear, then refetch (R5 R6)
    prep();
    put_desc(32'h100, OWN | FST, 12, 32'h1000, 32'h0);
    fill_buf(32'h1000, 12, 1'b0);
    put_desc(32'h110, LST, 8, 32'h1100, 32'h0);
    fill_buf(32'h1100, 8, 1'b0);
    go(1'b0, 1'b0);
    wait_stat(32'h10);
    chk(dma_status == 32'h210, "R5 unowned", dma_status, 32'h210);
    chk(tx_n == 3, "R5 no data moved", tx_n, 3);
    check_wb(1, "R7 first writeback");
    mem[32'h110/4] = OWN | LST; d_cfg[1] = OWN | LST;
    wr(2'd0, 32'h8000_0080);
    wait_stat(32'h1);
    chk(dma_status == 32'h311, "R6 refetch done", dma_status, 32'h311);
    check_data(1'b0, exp_n, "R6 refetch data");

    // oversize and zero size (R5)
    prep();
    put_desc(32'h100, OWN | LST, 8196, 32'h1000, 32'h0);
    go(1'b0, 1'b0);
    wait_stat(32'h10);
    chk(dma_status == 32'h210 && tx_n == 0, "R5 oversize", dma_status, 32'h210);
    prep();
    put_desc(32'h100, OWN | LST, 0, 32'h1000, 32'h0);
    go(1'b0, 1'b0);
    wait_stat(32'h10);
    chk(dma_status == 32'h210 && tx_n == 0, "R5 zero size", dma_status, 32'h210);

    // ring beats chain and returns to list base (R2)
    prep();
    put_desc(32'h100, OWN | CHN, 4, 32'h1000, 32'h200);
    fill_buf(32'h1000, 4, 1'b0);
    put_desc(32'h200, OWN | RING | CHN, 4, 32'h1100, 32'h300);
    fill_buf(32'h1100, 4, 1'b0);
    mem[32'h300/4] = OWN | LST; mem[32'h300/4+1] = 4; mem[32'h300/4+2] = 32'h1200; mem[32'h300/4+3] = 0;
    go(1'b0, 1'b0);
    wait_stat(32'h110);
    chk(dma_status == 32'h210, "R2 ring to base", dma_status, 32'h210);
    check_data(1'b0, 2, "R2 ring data");

    // bus error, halt across re-enable, soft reset (R9 R10)
    prep();
    put_desc(32'h100, OWN | LST, 8, 32'h0001_0000, 32'h0);
    go(1'b0, 1'b0);
    wait_stat(32'h4);
    chk(dma_status == 32'h204, "R9 bus error", dma_status, 32'h204);
    wr(2'd0, 32'h0); wr(2'd0, 32'h80);
    base_req = req_cnt;
    repeat (40) @(negedge clk);
    chk(req_cnt == base_req, "R9 halted", req_cnt, base_req);
    chk(dma_status == 32'h204, "R9 status kept", dma_status, 32'h204);
    wr(2'd0, 32'h83);
    @(negedge clk);
    chk(dma_status == 32'h0 && !mem_fixed_burst, "R10 soft reset", dma_status, 0);
    prep();
    put_desc(32'h100, OWN | LST, 16, 32'h1000, 32'h0);
    fill_buf(32'h1000, 16, 1'b1);
    go(1'b1, 1'b0);
    wait_stat(32'h100);
    chk(dma_status == 32'h102, "R10 works after reset", dma_status, 32'h102);
    check_data(1'b1, exp_n, "R4 rx after reset");

    // host abort (R12)
    prep();
    put_desc(32'h100, OWN | LST, 64, 32'h1000, 32'h0);
    fill_buf(32'h1000, 64, 1'b0);
    force_full = 1'b1;
    go(1'b0, 1'b0);
    repeat (60) @(negedge clk);
    wr(2'd0, 32'h0);
    @(negedge clk);
    base_req = req_cnt;
    repeat (20) @(negedge clk);
    chk(dma_status == 32'h600, "R12 abort status", dma_status, 32'h600);
    chk(req_cnt == base_req, "R12 stopped", req_cnt, base_req);
    force_full = 1'b0;

    // card error during transfer (R13 R7)
    prep();
    put_desc(32'h100, OWN | LST, 64, 32'h1000, 32'h0);
    fill_buf(32'h1000, 64, 1'b0);
    force_full = 1'b1;
    go(1'b0, 1'b0);
    repeat (30) @(negedge clk);
    card_err = 1'b1; @(negedge clk); card_err = 1'b0;
    force_full = 1'b0;
    wait_stat(32'h100);
    chk(dma_status == 32'h321, "R13 card error", dma_status, 32'h321);
    chk(mem[32'h100/4] == (LST | CES), "R7 card error writeback", mem[32'h100/4], LST | CES);
    check_data(1'b0, exp_n, "R3 data under card error");

    finish_run();
  end
endmodule